// File: doc/BRIEF.md
# Waiting-Tag-Aware Functional-Unit Select Arbiter

This block chooses which ready instruction issues to a single functional unit in a scheduler where several units share one set of result-tag broadcast lines. When two units in a group finish together, only one tag can be broadcast. The other tag stays parked in its unit's tag latch, and a per-unit flag marks it as still waiting. The arbiter keeps that parked tag safe. It sees the ready requests ordered by age, one kind bit per request (whether it writes a register tag), the unit's waiting flag and the number of waiting tags across the whole group.

An instruction that writes a tag is only eligible when its unit holds no waiting tag and the group's waiting count is below a configured limit. The default limit of one blocks every tag writer as soon as any tag in the group is waiting. A limit equal to the group size removes the group-level restriction. An instruction that writes no tag, such as a branch or a store, is always eligible. Among the eligible requests the oldest one wins. The logic is purely combinational. It has no storage and no clock.

Top module: `wkw_fu_select`

## Requirements
- R1: The grant vector has at most one bit set.
- R2: While `en` is low, the grant vector is all zeros.
- R3: Index 0 is the oldest request. Among eligible requests, the grant goes to the lowest eligible index.
- R4: While `tag_waiting` is high, no request whose `produces_tag` bit is 1 is granted.
- R5: A request with `produces_tag` = 0 stays eligible while `tag_waiting` is high. An older blocked tag writer does not stop a younger non-writer from winning.
- R6: While `group_wait_cnt` >= WAIT_LIMIT (default 1), no tag writer is granted. A non-writer may still be granted.
- R7: If `en` is high and at least one eligible request exists, exactly one grant is issued.
- R8: A grant bit is set only where the matching `req` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| en | input | 1 | Arbiter enable for this cycle |
| req | input | N_REQ | Ready requests; bit 0 is the oldest |
| produces_tag | input | N_REQ | Kind bit per request: 1 = writes a register tag |
| tag_waiting | input | 1 | This unit's latch holds a tag not yet broadcast |
| group_wait_cnt | input | CNT_W | Waiting tags in the sharing group, from the previous cycle |
| grant | output | N_REQ | One-hot (or zero) grant |

## Verification
The assertions assume that `group_wait_cnt` never exceeds GROUP_SIZE. They also assume that whenever `tag_waiting` is high the count is at least one, because the unit's own parked tag is part of the group total. The randomized stimulus draws the count from 0 to GROUP_SIZE and raises it to at least one whenever the waiting flag is set. Every hand-written table row also respects both conditions.

// File: rtl/wkw_sel_pkg.sv
package wkw_sel_pkg;
    typedef enum logic {
        KIND_NO_TAG = 1'b0,
        KIND_TAG    = 1'b1
    } req_kind_e;

    function automatic int unsigned cnt_width(input int unsigned group_size);
        return (group_size < 1) ? 1 : $clog2(group_size + 1);
    endfunction
endpackage

// File: rtl/wkw_tag_gate.sv
module wkw_tag_gate #(
    parameter int unsigned GROUP_SIZE = 2,
    parameter int unsigned WAIT_LIMIT = 1,
    localparam int unsigned CNT_W = wkw_sel_pkg::cnt_width(GROUP_SIZE)
) (
    input  logic             tag_waiting,
    input  logic [CNT_W-1:0] group_wait_cnt,
    output logic             tag_ok
);
    generate
        if (WAIT_LIMIT >= GROUP_SIZE) begin : g_unlimited
            logic unused_cnt;
            assign unused_cnt = ^group_wait_cnt;
            assign tag_ok = !tag_waiting;
        end else begin : g_limited
            assign tag_ok = !tag_waiting && (group_wait_cnt < CNT_W'(WAIT_LIMIT));
        end
    endgenerate
endmodule

// File: rtl/wkw_elig_mask.sv
module wkw_elig_mask #(
    parameter int unsigned N_REQ = 8
) (
    input  logic [N_REQ-1:0] req,
    input  logic [N_REQ-1:0] produces_tag,
    input  logic             tag_ok,
    output logic [N_REQ-1:0] eligible
);
    import wkw_sel_pkg::*;
    generate
        for (genvar i = 0; i < N_REQ; i++) begin : g_ent
            req_kind_e kind;
            assign kind        = req_kind_e'(produces_tag[i]);
            assign eligible[i] = req[i] && ((kind == KIND_NO_TAG) || tag_ok);
        end
    endgenerate
endmodule

// File: rtl/wkw_oldest_pick.sv
module wkw_oldest_pick #(
    parameter int unsigned N_REQ = 8
) (
    input  logic             en,
    input  logic [N_REQ-1:0] eligible,
    output logic [N_REQ-1:0] grant
);
    logic [N_REQ:0] older_any;
    assign older_any[0] = 1'b0;
    generate
        for (genvar i = 0; i < N_REQ; i++) begin : g_chain
            assign older_any[i+1] = older_any[i] | eligible[i];
            assign grant[i]       = en & eligible[i] & ~older_any[i];
        end
    endgenerate
endmodule

// File: rtl/wkw_fu_select.sv
module wkw_fu_select #(
    parameter int unsigned N_REQ      = 8,
    parameter int unsigned GROUP_SIZE = 2,
    parameter int unsigned WAIT_LIMIT = 1,
    localparam int unsigned CNT_W = wkw_sel_pkg::cnt_width(GROUP_SIZE)
) (
    input  logic             en,
    input  logic [N_REQ-1:0] req,
    input  logic [N_REQ-1:0] produces_tag,
    input  logic             tag_waiting,
    input  logic [CNT_W-1:0] group_wait_cnt,
    output logic [N_REQ-1:0] grant
);
    logic             tag_ok;
    logic [N_REQ-1:0] eligible;

    wkw_tag_gate #(.GROUP_SIZE(GROUP_SIZE), .WAIT_LIMIT(WAIT_LIMIT)) u_gate (
        .tag_waiting   (tag_waiting),
        .group_wait_cnt(group_wait_cnt),
        .tag_ok        (tag_ok)
    );

    wkw_elig_mask #(.N_REQ(N_REQ)) u_mask (
        .req         (req),
        .produces_tag(produces_tag),
        .tag_ok      (tag_ok),
        .eligible    (eligible)
    );

    wkw_oldest_pick #(.N_REQ(N_REQ)) u_pick (
        .en      (en),
        .eligible(eligible),
        .grant   (grant)
    );

    always_comb begin
        a_r1_onehot: assert ($onehot0(grant));
        a_r2_disabled: assert (en || (grant == '0));
        a_r3_oldest: assert ((grant == '0) || (((grant - N_REQ'(1)) & eligible) == '0));
        a_r4_no_overwrite: assert (!tag_waiting || ((grant & produces_tag) == '0));
        a_r5_nontag_passes: assert (!(en && tag_waiting && ((req & ~produces_tag) != '0))
                                    || ((grant & ~produces_tag) != '0));
        a_r6_group_limit: assert ((WAIT_LIMIT >= GROUP_SIZE)
                                  || (group_wait_cnt < CNT_W'(WAIT_LIMIT))
                                  || ((grant & produces_tag) == '0));
        a_r7_work_conserving: assert (!(en && (eligible != '0)) || (grant != '0));
        a_r8_req_only: assert ((grant & ~req) == '0);
    end
endmodule

// File: tb/wkw_fu_select_tb.sv
module wkw_fu_select_tb;
    localparam int unsigned N     = 8;
    localparam int unsigned GS    = 2;
    localparam int unsigned LIM   = 1;
    localparam int unsigned CW    = 2;
    localparam int unsigned NVEC  = 10;

    typedef struct packed {
        logic         en;
        logic [N-1:0] req;
        logic [N-1:0] typ;
        logic         ind;
        logic [CW-1:0] cnt;
        logic [N-1:0] exp;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 8'b0000_0110, 8'b0000_0000, 1'b0, 2'd0, 8'b0000_0010},
        '{1'b0, 8'b1111_1111, 8'b0000_0000, 1'b0, 2'd0, 8'b0000_0000},
        '{1'b1, 8'b0000_0011, 8'b0000_0001, 1'b1, 2'd1, 8'b0000_0010},
        '{1'b1, 8'b0000_0011, 8'b0000_0011, 1'b1, 2'd1, 8'b0000_0000},
        '{1'b1, 8'b1000_0000, 8'b0000_0000, 1'b0, 2'd0, 8'b1000_0000},
        '{1'b1, 8'b0000_0101, 8'b0000_0101, 1'b0, 2'd1, 8'b0000_0000},
        '{1'b1, 8'b0000_0101, 8'b0000_0101, 1'b0, 2'd0, 8'b0000_0001},
        '{1'b1, 8'b1111_0000, 8'b0111_0000, 1'b0, 2'd1, 8'b1000_0000},
        '{1'b1, 8'b0000_0000, 8'b0000_0000, 1'b0, 2'd0, 8'b0000_0000},
        '{1'b1, 8'b1111_1111, 8'b1111_1111, 1'b0, 2'd2, 8'b0000_0000}
    };
    localparam string VTAG [NVEC] = '{"R3", "R2", "R5", "R4", "R3", "R6", "R7", "R6", "R8", "R6"};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] typ = '0;
    logic ind = 1'b0;
    logic [CW-1:0] cnt = '0;
    logic [N-1:0] grant;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    wkw_fu_select #(.N_REQ(N), .GROUP_SIZE(GS), .WAIT_LIMIT(LIM)) u_dut (
        .en(en), .req(req), .produces_tag(typ), .tag_waiting(ind),
        .group_wait_cnt(cnt), .grant(grant)
    );

    function automatic logic [N-1:0] ref_grant(input logic e, input logic [N-1:0] r,
                                               input logic [N-1:0] t, input logic w,
                                               input logic [CW-1:0] c);
        logic [N-1:0] g = '0;
        logic tag_allowed = !w && (c < CW'(LIM));
        if (!e) return '0;
        for (int i = 0; i < N; i++) begin
            if (r[i] && (!t[i] || tag_allowed)) begin
                g[i] = 1'b1;
                return g;
            end
        end
        return g;
    endfunction

    task automatic apply_and_check(input logic e, input logic [N-1:0] r, input logic [N-1:0] t,
                                   input logic w, input logic [CW-1:0] c,
                                   input logic [N-1:0] exp, input string tag);
        @(posedge clk);
        en = e; req = r; typ = t; ind = w; cnt = c;
        @(negedge clk);
        checks++;
        if (grant !== exp) begin
            errors++;
            $display("FAIL %s: grant=%b expected=%b (req=%b typ=%b ind=%b cnt=%0d)",
                     tag, grant, exp, r, t, w, c);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: run did not complete");
        report();
    end

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // idle inputs: nothing granted (R2, R8)
        apply_and_check(1'b0, '0, '0, 1'b0, '0, '0, "R2");
        foreach (VECS[k])
            apply_and_check(VECS[k].en, VECS[k].req, VECS[k].typ, VECS[k].ind,
                            VECS[k].cnt, VECS[k].exp, VTAG[k]);
        // corner: youngest non-writer behind seven blocked writers, R5
        apply_and_check(1'b1, 8'hFF, 8'h7F, 1'b1, 2'd1, 8'h80, "R5");
        // corner: all writers, indicator clear, count clear: oldest wins, R1
        apply_and_check(1'b1, 8'hFF, 8'hFF, 1'b0, 2'd0, 8'h01, "R1");
        // randomized against reference model (R3, R4, R6)
        for (int n = 0; n < 400; n++) begin
            logic e = ($urandom_range(0, 7) != 0);
            logic [N-1:0] r = N'($urandom);
            logic [N-1:0] t = N'($urandom);
            logic w = $urandom_range(0, 1) == 1;
            logic [CW-1:0] c = CW'($urandom_range(0, GS));
            if (w && c == 0) c = 1;
            apply_and_check(e, r, t, w, c, ref_grant(e, r, t, w, c), "R3");
        end
        report();
    end
endmodule